// File: doc/BRIEF.md
# Level-Sensitive Interrupt Source Bank

This block holds a bank of level-sensitive interrupt sources. Each source keeps a two-bit pending/queued state (P in bit 1, Q in bit 0). The block's memory-mapped window gives every source its own 4 KB page. The upper address bits pick the source, and address bits 11:8 pick what an access does there: end the interrupt, read the state, or force the state to a fixed value. When a source fires, the block raises a notification that carries the source index. That notification is held on a valid/ready output until the consumer takes it.

Because the sources follow a level, a source whose input is still active triggers again in the same update that clears its P bit. Software that cannot remove the cause can silence a source by forcing its state to 01. Each input has its own polarity bit. When several sources fire together, their notifications leave one at a time, lowest index first.

Top module: `lsi_source_bank`

## Requirements
- R1: After reset every source is in state 00, notifyValid is low and mmioRespValid is low.
- R2: mmioReady is always high, so an access is taken in every cycle in which mmioValid is high. Address bits [ADDR_W-1:12] give the source index and bits 11:8 give the operation. Bits 7:0 are ignored, so a whole 256-byte range acts alike.
- R3: If a source's input is asserted while its state is 00, the state becomes 10 and one notification for that source is queued. An asserted input leaves states 10, 11 and 01 unchanged. With the output free, notifyValid shows the index two clock edges after the input is sampled asserted.
- R4: A load with operation 0x8 returns the source's state in mmioRdata[1:0] and leaves the state unchanged. Every load is answered by mmioRespValid one cycle after it is accepted, with mmioRdata[DATA_W-1:2] zero. Stores get no response.
- R5: A load or store with operation 0xC, 0xD, 0xE or 0xF forces the state to 00, 01, 10 or 11 (address bits 9:8). Such a load returns the previous state. No force except the one to 00 queues a notification, and that one does so only when the input is asserted.
- R6: A load with operation 0x0 or a store with operation 0x4 ends the interrupt. State 11 becomes 10 and queues a notification. State 10 becomes 00, and if the input is still asserted it returns to 10 in the same update and queues a notification. States 00 and 01 are unchanged. The end-of-interrupt load returns the previous state.
- R7: In state 01 (masked) a source queues no notification while its input is asserted. It leaves state 01 only through an access to its own page.
- R8: A load at any operation other than 0x0, 0x8 or 0xC–0xF reads zero and changes nothing. A store at any operation other than 0x4 or 0xC–0xF changes nothing.
- R9: srcActiveLow[i] set to 1 makes a low level on srcLevel[i] the asserted level. Set to 0, a high level is the asserted level.
- R10: Queued notifications leave lowest index first. notifyValid and notifyIdx hold steady until a cycle with notifyReady high, and each accepted handshake removes exactly one notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NUM_SRC | Raw interrupt input levels |
| srcActiveLow | input | NUM_SRC | Per-source polarity, 1 = asserted when low |
| mmioValid | input | 1 | Access request |
| mmioReady | output | 1 | Access accepted (always high) |
| mmioWrite | input | 1 | 1 = store, 0 = load |
| mmioAddr | input | ADDR_W | Offset within the window: source index and page offset |
| mmioRespValid | output | 1 | Load data valid, one cycle after the load |
| mmioRdata | output | DATA_W | Load data |
| notifyValid | output | 1 | A notification is offered |
| notifyReady | input | 1 | The consumer takes the offered notification |
| notifyIdx | output | IDX_W | Index of the source being notified |

## Verification
A wrong P/Q state cannot hide for long. It shows up on the next query load of that page, one cycle after the access. It also shows up as a missing or extra notification two edges after the input or operation that exposes it. A masked source that leaks is seen as a notification within two edges of its input rising. A lost or reordered queued notification shows as a wrong notifyIdx at the next handshake. An output that fails to hold shows as notifyIdx changing while notifyReady is low. The bench therefore follows every state-changing access with a query load and an exact-cycle check of the notification output.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

  typedef enum logic [1:0] {
    PQ_IDLE   = 2'b00,
    PQ_MASKED = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_t;

  // Strobes from the access decoder to the state datapath
  typedef struct packed {
    logic       eoi;
    logic       forcePq;
    logic [1:0] forceVal;
  } pqCmd_t;

  localparam logic [3:0] OP_LOAD_EOI  = 4'h0;
  localparam logic [3:0] OP_STORE_EOI = 4'h4;
  localparam logic [3:0] OP_QUERY     = 4'h8;

endpackage

// File: rtl/lsi_notify_arb.sv
module lsi_notify_arb #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] notifyEvt,
  input  logic               notifyReady,
  output logic               notifyValid,
  output logic [IDX_W-1:0]   notifyIdx
);

  logic [NUM_SRC-1:0] pendQ, pendD, grantMask;
  logic               outValidQ, outValidD;
  logic [IDX_W-1:0]   outIdxQ, outIdxD, pick;
  logic               found, canLoad;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
    canLoad   = !outValidQ || notifyReady;
    grantMask = (found && canLoad) ? (NUM_SRC'(1) << pick) : '0;
    pendD     = (pendQ & ~grantMask) | notifyEvt;
    outValidD = outValidQ;
    outIdxD   = outIdxQ;
    if (canLoad) begin
      outValidD = found;
      outIdxD   = found ? pick : outIdxQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= '0;
      outValidQ <= 1'b0;
      outIdxQ   <= '0;
    end else begin
      pendQ     <= pendD;
      outValidQ <= outValidD;
      outIdxQ   <= outIdxD;
    end
  end

  assign notifyValid = outValidQ;
  assign notifyIdx   = outIdxQ;

endmodule

// File: rtl/lsi_pq_datapath.sv
module lsi_pq_datapath
  import lsi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcLevel,
  input  logic [NUM_SRC-1:0]   srcActiveLow,
  input  pqCmd_t               cmd,
  input  logic [NUM_SRC-1:0]   cmdSel,
  input  logic                 notifyReady,
  output logic [2*NUM_SRC-1:0] pqAll,
  output logic                 notifyValid,
  output logic [IDX_W-1:0]     notifyIdx
);

  logic [NUM_SRC-1:0] notifyEvt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    pq_t  pqQ, afterCmd;
    logic asserted, fire;

    assign asserted = srcLevel[i] ^ srcActiveLow[i];

    always_comb begin
      afterCmd = pqQ;
      fire     = 1'b0;
      if (cmdSel[i]) begin
        if (cmd.forcePq) begin
          afterCmd = pq_t'(cmd.forceVal);
        end else if (cmd.eoi) begin
          case (pqQ)
            PQ_QUEUED: begin
              afterCmd = PQ_PEND;
              fire     = 1'b1;
            end
            PQ_PEND: afterCmd = PQ_IDLE;
            default: afterCmd = pqQ;
          endcase
        end
      end
      // level re-evaluated after the access: P cleared with input active fires again
      if (afterCmd == PQ_IDLE && asserted) begin
        afterCmd = PQ_PEND;
        fire     = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) pqQ <= PQ_IDLE;
      else       pqQ <= afterCmd;
    end

    assign pqAll[2*i +: 2] = pqQ;
    assign notifyEvt[i]    = fire;
  end

  lsi_notify_arb #(
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) uArb (
    .clk        (clk),
    .rstN       (rstN),
    .notifyEvt  (notifyEvt),
    .notifyReady(notifyReady),
    .notifyValid(notifyValid),
    .notifyIdx  (notifyIdx)
  );

endmodule

// File: rtl/lsi_mmio_ctrl.sv
module lsi_mmio_ctrl
  import lsi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mmioValid,
  input  logic                 mmioWrite,
  input  logic [ADDR_W-1:0]    mmioAddr,
  input  logic [2*NUM_SRC-1:0] pqAll,
  output logic                 mmioReady,
  output pqCmd_t               cmd,
  output logic [NUM_SRC-1:0]   cmdSel,
  output logic                 respValid,
  output logic [DATA_W-1:0]    rdata
);

  logic [IDX_W-1:0] srcIdx;
  logic [3:0]       opNib;
  logic             inRange, readHit;
  logic [1:0]       selPq;
  logic             unusedLowAddr;

  assign mmioReady     = 1'b1;
  assign srcIdx        = mmioAddr[ADDR_W-1:12];
  assign opNib         = mmioAddr[11:8];
  assign unusedLowAddr = ^mmioAddr[7:0];
  assign inRange       = int'(srcIdx) < NUM_SRC;

  always_comb begin
    cmd     = '0;
    readHit = 1'b0;
    case (opNib)
      OP_LOAD_EOI: if (!mmioWrite) begin
        cmd.eoi = 1'b1;
        readHit = 1'b1;
      end
      OP_STORE_EOI: if (mmioWrite) cmd.eoi = 1'b1;
      OP_QUERY:     if (!mmioWrite) readHit = 1'b1;
      4'hC, 4'hD, 4'hE, 4'hF: begin
        cmd.forcePq  = 1'b1;
        cmd.forceVal = opNib[1:0];
        readHit      = !mmioWrite;
      end
      default: ;
    endcase
    if (!mmioValid || !inRange) begin
      cmd     = '0;
      readHit = 1'b0;
    end
    cmdSel = (mmioValid && inRange) ? (NUM_SRC'(1) << srcIdx) : '0;
  end

  always_comb begin
    selPq = 2'b00;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcIdx == IDX_W'(i)) selPq = pqAll[2*i +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      rdata     <= '0;
    end else begin
      respValid <= mmioValid && !mmioWrite;
      rdata     <= readHit ? DATA_W'(selPq) : '0;
    end
  end

endmodule

// File: rtl/lsi_source_bank.sv
module lsi_source_bank
  import lsi_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = IDX_W + 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_SRC-1:0] srcActiveLow,
  input  logic               mmioValid,
  output logic               mmioReady,
  input  logic               mmioWrite,
  input  logic [ADDR_W-1:0]  mmioAddr,
  output logic               mmioRespValid,
  output logic [DATA_W-1:0]  mmioRdata,
  output logic               notifyValid,
  input  logic               notifyReady,
  output logic [IDX_W-1:0]   notifyIdx
);

  pqCmd_t               cmd;
  logic [NUM_SRC-1:0]   cmdSel;
  logic [2*NUM_SRC-1:0] pqAll;

  lsi_mmio_ctrl #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .mmioValid(mmioValid),
    .mmioWrite(mmioWrite),
    .mmioAddr (mmioAddr),
    .pqAll    (pqAll),
    .mmioReady(mmioReady),
    .cmd      (cmd),
    .cmdSel   (cmdSel),
    .respValid(mmioRespValid),
    .rdata    (mmioRdata)
  );

  lsi_pq_datapath #(
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .srcLevel    (srcLevel),
    .srcActiveLow(srcActiveLow),
    .cmd         (cmd),
    .cmdSel      (cmdSel),
    .notifyReady (notifyReady),
    .pqAll       (pqAll),
    .notifyValid (notifyValid),
    .notifyIdx   (notifyIdx)
  );

endmodule

// File: rtl/lsi_source_bank_chk.sv
module lsi_source_bank_chk #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 15
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SRC-1:0]   srcLevel,
  input logic [NUM_SRC-1:0]   srcActiveLow,
  input logic                 mmioValid,
  input logic                 mmioWrite,
  input logic [ADDR_W-1:0]    mmioAddr,
  input logic                 mmioRespValid,
  input logic [DATA_W-1:0]    mmioRdata,
  input logic                 notifyValid,
  input logic                 notifyReady,
  input logic [IDX_W-1:0]     notifyIdx,
  input logic [2*NUM_SRC-1:0] pqAll
);

  // R10: the offered notification holds until it is taken
  assert_notify_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid && !notifyReady |=> notifyValid && $stable(notifyIdx));

  // R4: every load is answered in the next cycle
  assert_load_resp_R4: assert property (@(posedge clk) disable iff (!rstN)
    mmioValid && !mmioWrite |=> mmioRespValid);

  // R4: stores get no response
  assert_store_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(mmioValid && !mmioWrite) |=> !mmioRespValid);

  // R4: only the two state bits may be non-zero
  assert_rdata_narrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    mmioRespValid |-> mmioRdata[DATA_W-1:2] == '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcChk
    logic touched, active;
    assign touched = mmioValid && (mmioAddr[ADDR_W-1:12] == IDX_W'(i));
    assign active  = srcLevel[i] ^ srcActiveLow[i];

    // R7: masked state is left only through the source's own page
    assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      pqAll[2*i +: 2] == 2'b01 && !touched |=> pqAll[2*i +: 2] == 2'b01);

    // R3: an idle source with an active input moves to pending
    assert_level_fire_R3: assert property (@(posedge clk) disable iff (!rstN)
      pqAll[2*i +: 2] == 2'b00 && active && !touched |=> pqAll[2*i +: 2] == 2'b10);
  end

endmodule

bind lsi_source_bank lsi_source_bank_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .ADDR_W (ADDR_W)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .srcLevel     (srcLevel),
  .srcActiveLow (srcActiveLow),
  .mmioValid    (mmioValid),
  .mmioWrite    (mmioWrite),
  .mmioAddr     (mmioAddr),
  .mmioRespValid(mmioRespValid),
  .mmioRdata    (mmioRdata),
  .notifyValid  (notifyValid),
  .notifyReady  (notifyReady),
  .notifyIdx    (notifyIdx),
  .pqAll        (pqAll)
);

// File: tb/lsi_source_bank_test.sv
`timescale 1ns/1ps
module lsi_source_bank_test;
  localparam int N  = 8;
  localparam int DW = 64;
  localparam int IW = 3;
  localparam int AW = IW + 12;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  srcLevel, srcActiveLow;
  logic          mmioValid, mmioWrite, mmioReady, mmioRespValid;
  logic [AW-1:0] mmioAddr;
  logic [DW-1:0] mmioRdata;
  logic          notifyValid, notifyReady;
  logic [IW-1:0] notifyIdx;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  lsi_source_bank #(.NUM_SRC(N), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcActiveLow(srcActiveLow),
    .mmioValid(mmioValid), .mmioReady(mmioReady), .mmioWrite(mmioWrite),
    .mmioAddr(mmioAddr), .mmioRespValid(mmioRespValid), .mmioRdata(mmioRdata),
    .notifyValid(notifyValid), .notifyReady(notifyReady), .notifyIdx(notifyIdx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic wr, input int src, input logic [11:0] off,
                        output logic [63:0] rd);
    mmioValid = 1'b1;
    mmioWrite = wr;
    mmioAddr  = {IW'(src), off};
    check("R2 ready", 64'(mmioReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    mmioValid = 1'b0;
    mmioWrite = 1'b0;
    rd = mmioRdata;
    check("R4 response flag", 64'(mmioRespValid), wr ? 64'd0 : 64'd1);
  endtask

  task automatic getPq(input int src, input logic [1:0] exp, input string req);
    logic [63:0] rd;
    access(1'b0, src, 12'h800, rd);
    check(req, rd, 64'(exp));
  endtask

  task automatic expectNotify(input int idx, input string req);
    check(req, 64'(notifyValid), 64'd1);
    check(req, 64'(notifyIdx), 64'(idx));
  endtask

  task automatic expectQuiet(input string req);
    check(req, 64'(notifyValid), 64'd0);
  endtask

  task automatic takeNotify();
    notifyReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    notifyReady = 1'b0;
  endtask

  task automatic testReset();
    check("R1 notify idle", 64'(notifyValid), 64'd0);
    check("R1 no response", 64'(mmioRespValid), 64'd0);
    getPq(3, 2'b00, "R1 state 00");
    getPq(4, 2'b00, "R9 active-low high input idle");
  endtask

  task automatic testTrigger();
    srcLevel[2] = 1'b1;
    tick();
    tick();
    expectNotify(2, "R3 notify idx 2");
    getPq(2, 2'b10, "R3 state 10");
    takeNotify();
    tick();
    expectQuiet("R3 held level no repeat");
    getPq(2, 2'b10, "R3 held level keeps 10");
  endtask

  task automatic testEoiRetrigger();
    logic [63:0] rd;
    access(1'b0, 2, 12'h000, rd);
    check("R6 eoi load old value", rd, 64'h2);
    tick();
    expectNotify(2, "R6 retrigger notify");
    takeNotify();
    getPq(2, 2'b10, "R6 retrigger state");
    srcLevel[2] = 1'b0;
    access(1'b1, 2, 12'h400, rd);
    tick();
    expectQuiet("R6 eoi no retrigger");
    getPq(2, 2'b00, "R6 eoi 10 to 00");
  endtask

  task automatic testMask();
    logic [63:0] rd;
    access(1'b1, 5, 12'hD40, rd);
    getPq(5, 2'b01, "R5 store in D range masks");
    srcLevel[5] = 1'b1;
    tick();
    tick();
    expectQuiet("R7 masked no notify");
    getPq(5, 2'b01, "R7 masked state kept");
    access(1'b0, 5, 12'hD00, rd);
    check("R5 force load old value", rd, 64'h1);
    access(1'b0, 5, 12'hC80, rd);
    check("R5 unmask load old value", rd, 64'h1);
    tick();
    expectNotify(5, "R5 force 00 with active input");
    takeNotify();
    getPq(5, 2'b10, "R5 state after unmask");
    srcLevel[5] = 1'b0;
    access(1'b1, 5, 12'h400, rd);
    getPq(5, 2'b00, "R6 cleanup");
  endtask

  task automatic testQueuedEoi();
    logic [63:0] rd;
    access(1'b1, 1, 12'hF00, rd);
    getPq(1, 2'b11, "R5 force 11");
    expectQuiet("R5 force 11 no notify");
    access(1'b0, 1, 12'h000, rd);
    check("R6 eoi from 11 old value", rd, 64'h3);
    tick();
    expectNotify(1, "R6 eoi 11 renotify");
    takeNotify();
    getPq(1, 2'b10, "R6 eoi 11 to 10");
    access(1'b1, 1, 12'h4FF, rd);
    getPq(1, 2'b00, "R2 eoi at top of range");
    access(1'b1, 1, 12'hE00, rd);
    tick();
    expectQuiet("R5 force 10 no notify");
    getPq(1, 2'b10, "R5 force 10");
    access(1'b1, 1, 12'hC00, rd);
    getPq(1, 2'b00, "R5 force 00 idle input");
  endtask

  task automatic testArbitration();
    logic [63:0] rd;
    srcLevel[6] = 1'b1;
    srcLevel[3] = 1'b1;
    tick();
    tick();
    expectNotify(3, "R10 lowest index first");
    for (int k = 0; k < 3; k++) begin
      tick();
      expectNotify(3, "R10 hold while not ready");
    end
    takeNotify();
    expectNotify(6, "R10 next after handshake");
    takeNotify();
    expectQuiet("R10 one per handshake");
    srcLevel[6] = 1'b0;
    srcLevel[3] = 1'b0;
    access(1'b1, 6, 12'h400, rd);
    access(1'b1, 3, 12'h400, rd);
    getPq(6, 2'b00, "R6 cleanup 6");
    getPq(3, 2'b00, "R6 cleanup 3");
  endtask

  task automatic testPolarity();
    logic [63:0] rd;
    srcLevel[4] = 1'b0;
    tick();
    tick();
    expectNotify(4, "R9 active-low fires on low");
    takeNotify();
    srcLevel[4] = 1'b1;
    access(1'b1, 4, 12'h400, rd);
    tick();
    expectQuiet("R9 high input idle");
    getPq(4, 2'b00, "R9 cleared");
  endtask

  task automatic testUndefined();
    logic [63:0] rd;
    access(1'b1, 2, 12'hE00, rd);
    access(1'b0, 2, 12'h200, rd);
    check("R8 unused op reads zero", rd, 64'h0);
    access(1'b0, 2, 12'h400, rd);
    check("R8 load at store-eoi reads zero", rd, 64'h0);
    access(1'b1, 2, 12'h000, rd);
    access(1'b1, 2, 12'h800, rd);
    access(1'b1, 2, 12'h300, rd);
    tick();
    expectQuiet("R8 no notify");
    getPq(2, 2'b10, "R8 state untouched");
    access(1'b1, 2, 12'hC00, rd);
    getPq(2, 2'b00, "R5 cleanup");
  endtask

  initial begin
    rstN = 1'b0;
    srcLevel = '0;
    srcLevel[4] = 1'b1;
    srcActiveLow = '0;
    srcActiveLow[4] = 1'b1;
    mmioValid = 1'b0;
    mmioWrite = 1'b0;
    mmioAddr = '0;
    notifyReady = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testTrigger();
    testEoiRetrigger();
    testMask();
    testQueuedEoi();
    testArbitration();
    testPolarity();
    testUndefined();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule